// File: doc/BRIEF.md
# Paced Memory Scrub Controller

The block walks a range of memory lines in the background and asks the memory side to scrub one line at a time: read, correct and write back. A programmable spacing sets how often a new line is requested, so scrubbing takes only a small, bounded share of memory bandwidth. Software sets the block up through a 16-bit control word. The word holds a mode field that switches scrubbing on or off, a rate field that selects a fast or a slow spacing, and a read-only two-bit count of completed passes over the range.

Each request carries a line address and stays up until the memory side acknowledges it. The address then moves on to the next line. After the top line it returns to zero, and that return counts as one finished pass. The block does not access DRAM, compute ECC or translate bus traffic. It only sets the pace and the order of the scrub requests.

Top module: `scrub_top`

## Requirements
- R1: After reset the control word reads 0x0000, no request is raised and the line address is zero.
- R2: A write stores bits 3:0 (mode in 1:0, rate in 3:2). Bits 6:5 read back the pass count and a write does not change them. All other bits read as zero.
- R3: Requests are launched only while the mode field equals binary 10. The encodings 00, 01 and 11 launch no new request.
- R4: With rate code 01 (fast), a new request is launched every FAST_IVL (default 256) clock cycles.
- R5: With rate code 10 (normal), a new request is launched every SLOW_IVL (default 32000) clock cycles.
- R6: With rate code 00 or 11 and the mode on, the block uses the normal spacing.
- R7: Every write to the control word restarts the spacing timer. The next request rises exactly one interval after the clock edge that takes the write.
- R8: A raised request stays high, with a stable address, until it is acknowledged. It drops on the cycle after the acknowledge. No new request starts while one is pending, and turning the mode off does not withdraw a pending request.
- R9: Each acknowledged request advances the line address by one. From TOP_ADDR it returns to zero.
- R10: Each return of the address to zero adds one to the pass count in bits 6:5, modulo 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control word write strobe |
| regWrData | input | 16 | Control word write data |
| regRdData | output | 16 | Control word read data |
| scrubReq | output | 1 | Scrub request toward memory |
| scrubAddr | output | ADDR_W | Line address of the current request |
| scrubAck | input | 1 | Acknowledge from memory for the pending request |

## Verification
The assertions assume that the memory side raises the acknowledge only while a request is pending, and only for a single cycle each time. The bench responder follows that rule: it drives the acknowledge only after it has seen the request high, and it lowers it at the next falling edge. The responder latency can be changed, including an indefinite stall. The address checks also assume the acknowledge never comes back faster than one interval, and the spacing check assumes writes reach the register only through the write strobe. The stimulus writes only at falling edges.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  localparam int CFG_W  = 4;
  localparam int PASS_W = 2;

  localparam logic [1:0] MODE_ON   = 2'b10;
  localparam logic [1:0] RATE_FAST = 2'b01;

  typedef struct packed {
    logic [1:0] rate;
    logic [1:0] mode;
  } scrubCfg_t;

  // strobes from control toward the address/pass datapath
  typedef struct packed {
    logic advance;
    logic launch;
  } scrubStrobes_t;

endpackage

// File: rtl/scrub_ctrl.sv
module scrub_ctrl
  import scrub_pkg::*;
#(
  parameter int FAST_IVL = 256,
  parameter int SLOW_IVL = 32000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  scrubCfg_t     cfgIn,
  input  logic          scrubAck,
  output scrubCfg_t     cfgOut,
  output logic          scrubReq,
  output scrubStrobes_t strobes
);

  localparam int MAX_IVL = (FAST_IVL > SLOW_IVL) ? FAST_IVL : SLOW_IVL;
  localparam int TW      = $clog2(MAX_IVL + 1);
  localparam logic [TW-1:0] FAST_LAST = TW'(FAST_IVL - 1);
  localparam logic [TW-1:0] SLOW_LAST = TW'(SLOW_IVL - 1);

  scrubCfg_t     cfgQ;
  logic [TW-1:0] timerQ;
  logic          reqQ;
  logic          scrubOn;
  logic [TW-1:0] lastTick;
  logic          expired;
  logic          launch;
  logic          advance;

  assign scrubOn  = (cfgQ.mode == MODE_ON);
  assign lastTick = (cfgQ.rate == RATE_FAST) ? FAST_LAST : SLOW_LAST;
  assign expired  = (timerQ == lastTick);
  assign launch   = !regWrEn && scrubOn && expired && !reqQ;
  assign advance  = reqQ && scrubAck;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ   <= '0;
      timerQ <= '0;
    end else if (regWrEn) begin
      cfgQ   <= cfgIn;
      timerQ <= '0;
    end else if (!scrubOn) begin
      timerQ <= '0;
    end else if (expired) begin
      if (!reqQ) timerQ <= '0;
    end else begin
      timerQ <= timerQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        reqQ <= 1'b0;
    else if (advance) reqQ <= 1'b0;
    else if (launch)  reqQ <= 1'b1;
  end

  assign cfgOut          = cfgQ;
  assign scrubReq        = reqQ;
  assign strobes.advance = advance;
  assign strobes.launch  = launch;

endmodule

// File: rtl/scrub_datapath.sv
module scrub_datapath
  import scrub_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int TOP_ADDR = 1023
) (
  input  logic              clk,
  input  logic              rstN,
  input  scrubStrobes_t     strobes,
  output logic [ADDR_W-1:0] scrubAddr,
  output logic [PASS_W-1:0] passCnt
);

  localparam logic [ADDR_W-1:0] TOP_L = ADDR_W'(TOP_ADDR);

  logic [ADDR_W-1:0] addrQ;
  logic [PASS_W-1:0] passQ;
  logic              atTop;
  logic              unusedLaunch;

  assign unusedLaunch = strobes.launch;

  generate
    if (TOP_ADDR == (2 ** ADDR_W) - 1) begin : g_fullRange
      assign atTop = &addrQ;
    end else begin : g_partRange
      assign atTop = (addrQ == TOP_L);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      passQ <= '0;
    end else if (strobes.advance) begin
      if (atTop) begin
        addrQ <= '0;
        passQ <= passQ + 1'b1;
      end else begin
        addrQ <= addrQ + 1'b1;
      end
    end
  end

  assign scrubAddr = addrQ;
  assign passCnt   = passQ;

endmodule

// File: rtl/scrub_top.sv
module scrub_top
  import scrub_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int TOP_ADDR = 1023,
  parameter int FAST_IVL = 256,
  parameter int SLOW_IVL = 32000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  output logic              scrubReq,
  output logic [ADDR_W-1:0] scrubAddr,
  input  logic              scrubAck
);

  localparam int RSVD_HI_W = 16 - 7;

  scrubCfg_t         cfgIn;
  scrubCfg_t         cfgCur;
  scrubStrobes_t     strobes;
  logic [PASS_W-1:0] passCnt;
  logic [11:0]       unusedWrBits;

  assign cfgIn        = scrubCfg_t'(regWrData[CFG_W-1:0]);
  assign unusedWrBits = regWrData[15:4];

  scrub_ctrl #(
    .FAST_IVL(FAST_IVL),
    .SLOW_IVL(SLOW_IVL)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .cfgIn    (cfgIn),
    .scrubAck (scrubAck),
    .cfgOut   (cfgCur),
    .scrubReq (scrubReq),
    .strobes  (strobes)
  );

  scrub_datapath #(
    .ADDR_W  (ADDR_W),
    .TOP_ADDR(TOP_ADDR)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .scrubAddr (scrubAddr),
    .passCnt   (passCnt)
  );

  assign regRdData = {{RSVD_HI_W{1'b0}}, passCnt, 1'b0, cfgCur.rate, cfgCur.mode};

endmodule

// File: rtl/scrub_checker.sv
module scrub_checker #(
  parameter int ADDR_W   = 16,
  parameter int TOP_ADDR = 1023,
  parameter int FAST_IVL = 256,
  parameter int SLOW_IVL = 32000
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [15:0]       regRdData,
  input logic              scrubReq,
  input logic [ADDR_W-1:0] scrubAddr,
  input logic              scrubAck
);

  localparam logic [ADDR_W-1:0] TOP_L = ADDR_W'(TOP_ADDR);

  int   gapQ;
  logic reqD;
  int   minGap;

  assign minGap = (regRdData[3:2] == 2'b01) ? FAST_IVL - 1 : SLOW_IVL - 1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapQ <= 0;
      reqD <= 1'b0;
    end else begin
      reqD <= scrubReq;
      if (regWrEn || regRdData[1:0] != 2'b10 || (scrubReq && !reqD)) gapQ <= 0;
      else gapQ <= gapQ + 1;
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[15:7] == '0 && regRdData[4] == 1'b0); // R2

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!scrubReq && regRdData[1:0] != 2'b10) |=> !scrubReq); // R3

  AST_MIN_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (scrubReq && !reqD) |-> gapQ >= minGap); // R4

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (scrubReq && !scrubAck) |=> (scrubReq && $stable(scrubAddr))); // R8

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (scrubReq && scrubAck) |=> !scrubReq); // R8

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (scrubReq && scrubAck) |=>
      scrubAddr == (($past(scrubAddr) == TOP_L) ? '0 : $past(scrubAddr) + 1'b1)); // R9

  AST_ADDR_STILL: assert property (@(posedge clk) disable iff (!rstN)
    !(scrubReq && scrubAck) |=> $stable(scrubAddr)); // R9

  AST_PASS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (scrubReq && scrubAck && scrubAddr == TOP_L) |=>
      regRdData[6:5] == $past(regRdData[6:5]) + 2'd1); // R10

  AST_PASS_STILL: assert property (@(posedge clk) disable iff (!rstN)
    !(scrubReq && scrubAck && scrubAddr == TOP_L) |=> $stable(regRdData[6:5])); // R10

endmodule

bind scrub_top scrub_checker #(
  .ADDR_W  (ADDR_W),
  .TOP_ADDR(TOP_ADDR),
  .FAST_IVL(FAST_IVL),
  .SLOW_IVL(SLOW_IVL)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regRdData (regRdData),
  .scrubReq  (scrubReq),
  .scrubAddr (scrubAddr),
  .scrubAck  (scrubAck)
);

// File: tb/tb_scrub_top.sv
`timescale 1ns/1ps
module tb_scrub_top;
  localparam int AW   = 8;
  localparam int TOPA = 3;
  localparam int FAST = 256;
  localparam int SLOW = 32000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [15:0]   regWrData = '0;
  logic [15:0]   regRdData;
  logic          scrubReq;
  logic [AW-1:0] scrubAddr;
  logic          scrubAck = 1'b0;

  always #2.5 clk = ~clk;

  scrub_top #(.ADDR_W(AW), .TOP_ADDR(TOPA), .FAST_IVL(FAST), .SLOW_IVL(SLOW)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .scrubReq(scrubReq), .scrubAddr(scrubAddr), .scrubAck(scrubAck)
  );

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int cyc = 0, lastWr = 0;
  int mMode = 0, mRate = 0, mTimer = 0, mReq = 0, mAddr = 0, mPass = 0;
  always @(posedge clk) begin
    int ivl;
    bit fire, adv;
    cyc++;
    if (regWrEn) lastWr = cyc;
    if (!rstN) begin
      mMode = 0; mRate = 0; mTimer = 0; mReq = 0; mAddr = 0; mPass = 0;
    end else begin
      ivl  = (mRate == 1) ? FAST : SLOW;
      fire = !regWrEn && mMode == 2 && mTimer == ivl - 1 && mReq == 0;
      adv  = mReq == 1 && scrubAck;
      if (regWrEn) begin
        mMode = regWrData[1:0]; mRate = regWrData[3:2]; mTimer = 0;
      end else if (mMode != 2) mTimer = 0;
      else if (mTimer == ivl - 1) begin
        if (mReq == 0) mTimer = 0;
      end else mTimer++;
      if (adv) begin
        mReq = 0;
        if (mAddr == TOPA) begin mAddr = 0; mPass = (mPass + 1) % 4; end
        else mAddr++;
      end else if (fire) mReq = 1;
    end
  end

  // per-cycle comparison and rise tracking
  int riseCnt = 0, lastRise = 0, gapLast = 0, sinceWr = 0;
  bit prevReq = 0;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(scrubReq == mReq[0], "R8 req", scrubReq, mReq);
      check(scrubAddr == AW'(mAddr), "R9 addr", scrubAddr, mAddr);
      check(regRdData == 16'((mPass << 5) | (mRate << 2) | mMode), "R2 word",
            regRdData, (mPass << 5) | (mRate << 2) | mMode);
      if (scrubReq && !prevReq) begin
        riseCnt++;
        gapLast  = cyc - lastRise;
        sinceWr  = cyc - lastWr;
        lastRise = cyc;
      end
    end
    prevReq = scrubReq;
  end

  // memory-side responder
  int ackDelay = 0, waitCnt = 0, ackCount = 0;
  bit holdAck = 0;
  always @(negedge clk) begin
    if (scrubAck) begin
      scrubAck = 1'b0;
      ackCount++;
    end else if (scrubReq && !holdAck) begin
      if (waitCnt >= ackDelay) begin
        scrubAck = 1'b1;
        waitCnt = 0;
      end else waitCnt++;
    end
  end

  task automatic writeReg(input logic [15:0] v);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic waitRises(input int n);
    int target;
    target = riseCnt + n;
    while (riseCnt < target) begin @(negedge clk); #1; end
  endtask

  task automatic waitAcks(input int n);
    while (ackCount < n) begin @(negedge clk); #1; end
  endtask

  task automatic summary;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    #(190000 * 5);
    testsFailed++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int base;
    idle(5);
    rstN = 1'b1;
    idle(2);
    // R1 reset state
    check(regRdData == 16'h0000, "R1 word", regRdData, 0);
    check(scrubReq == 1'b0, "R1 req", scrubReq, 0);
    check(scrubAddr == '0, "R1 addr", scrubAddr, 0);

    // R2 / R3 : bad mode encodings launch nothing
    writeReg(16'h0005);
    check(regRdData == 16'h0005, "R2 readback", regRdData, 5);
    base = riseCnt;
    idle(600);
    check(riseCnt == base, "R3 mode 01", riseCnt - base, 0);
    writeReg(16'hFFFF);
    check(regRdData == 16'h000F, "R2 masked", regRdData, 15);
    idle(600);
    check(riseCnt == base, "R3 mode 11", riseCnt - base, 0);

    // R7 / R4 fast spacing
    writeReg(16'h0006);
    waitRises(1);
    check(sinceWr == FAST, "R7 first fast", sinceWr, FAST);
    idle(100);
    writeReg(16'h0006);
    waitRises(1);
    check(sinceWr == FAST, "R7 restart", sinceWr, FAST);
    ackDelay = 3;
    waitRises(1);
    check(gapLast == FAST, "R4 gap", gapLast, FAST);
    idle(2);
    check(scrubReq == 1'b1, "R8 held", scrubReq, 1);
    waitAcks(5);
    check(scrubAddr == AW'(1), "R9 addr after 5", scrubAddr, 1);
    check(regRdData[6:5] == 2'd1, "R10 pass 1", regRdData[6:5], 1);
    ackDelay = 0;
    waitRises(1);
    check(gapLast == FAST, "R4 gap 2", gapLast, FAST);
    waitAcks(16);
    check(scrubAddr == '0, "R9 wrap", scrubAddr, 0);
    check(regRdData[6:5] == 2'd0, "R10 mod 4", regRdData[6:5], 0);

    // R8 pending request survives mode off
    holdAck = 1;
    waitRises(1);
    writeReg(16'h0000);
    idle(5);
    check(scrubReq == 1'b1, "R8 pending kept", scrubReq, 1);
    holdAck = 0;
    idle(3);
    check(scrubReq == 1'b0, "R8 dropped", scrubReq, 0);
    base = riseCnt;
    idle(600);
    check(riseCnt == base, "R3 mode 00", riseCnt - base, 0);

    // R5 normal spacing
    writeReg(16'h000A);
    waitRises(1);
    check(sinceWr == SLOW, "R5 first", sinceWr, SLOW);
    waitRises(1);
    check(gapLast == SLOW, "R5 gap", gapLast, SLOW);

    // R6 rate fallback
    writeReg(16'h0002);
    waitRises(1);
    check(sinceWr == SLOW, "R6 rate 00", sinceWr, SLOW);
    writeReg(16'h000E);
    waitRises(1);
    check(sinceWr == SLOW, "R6 rate 11", sinceWr, SLOW);
    idle(4);
    summary();
  end
endmodule